// File: doc/BRIEF.md
# Link Service Request Detector

This block watches the handshake pins of two point-to-point byte links while those links are idle on the local side. When a remote device raises its acknowledge pin (it wants to receive, so the local side should transmit) or its clock pin (it wants to send), and the local port is not in use, the detector records a service request. There is one transmit request and one receive request per port. Each request passes only if its own mask bit is set.

The four request bits and the four mask bits appear together in one 32-bit status word. A single interrupt line is the OR of the four requests, gated by a global enable. A priority index reports the leading-zero count of the status word, so software can tell which request to serve first without scanning the word.

A port is in use when an enabled buffer is assigned to it. Two buffers can each be steered to either port. When both buffers are enabled and steered to the same port, the link is looped back on itself. The other port is then idle only because of that steering, and it must stay silent.

Top module: `link_svc_req_det`

## Requirements
- R1: After reset the four request bits, the interrupt output and all status word bits except the mask field are 0, and the priority index holds the no-request code 4.
- R2: The transmit request of port p is set when its acknowledge pin is high, transmit mask bit p is 1 and port p is idle. It is 0 whenever the transmit mask bit is 0.
- R3: The receive request of port p is set when its clock pin is high, receive mask bit p is 1 and port p is idle.
- R4: Port p is idle when no enabled buffer is steered to it. A buffer steered to p but disabled leaves p idle. An enabled buffer steered to p makes p busy, and a busy port raises no request.
- R5: When both buffers are enabled and steered to the same port, the other port raises no request. This holds even though no buffer is assigned to it. If either buffer is disabled, this rule does not apply.
- R6: The interrupt output is the OR of the four request bits, and it is raised only when the global enable is 1.
- R7: Each pin passes through two synchronizer flops. A request bit changes on the third rising edge after a pin change, and the interrupt output follows one edge later, on the fourth.
- R8: Request bits do not latch. A bit clears when its pin falls, when its mask clears, or when its port becomes busy.
- R9: The status word holds the requests in bits 31..28 in the order port-1 transmit, port-1 receive, port-0 transmit, port-0 receive. It holds the masks in bits 3..0 in the same order. All other bits are 0.
- R10: The priority index equals the number of leading zeros of the status word when any request is set. That gives 0 for port-1 transmit through 3 for port-0 receive. It gives 4 when no request is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| ack_pin | input | 2 | Acknowledge pin level per port |
| lclk_pin | input | 2 | Link clock pin level per port |
| buf_en | input | 2 | Enable of buffer 0 and buffer 1 |
| buf_port | input | 2 | Port each buffer is steered to (bit b = port of buffer b) |
| tx_mask | input | 2 | Transmit request mask per port |
| rx_mask | input | 2 | Receive request mask per port |
| irq_en | input | 1 | Global interrupt enable |
| req_word | output | 32 | Request and mask status word |
| req_idx | output | 3 | Leading-zero priority index, 4 when none |
| svc_irq | output | 1 | Service request interrupt |

## Verification
The hardest condition to reach is the looped-back steering. There, a port with no buffer assigned to it must still stay quiet, unlike an ordinary unassigned port. The stimulus holds both pins of both ports high with all masks open. It then steps the two steering bits and the two enables through the loopback cases: both buffers on port 1, both buffers on port 0, and the same steering with one buffer disabled. At each step it compares the full status word against a model.

A second difficult point is the exact latency. The bench schedules expected items at the second, third and fourth edges after a single pin change, so a missing or extra flop stage is detected.

// File: rtl/link_svc_req_det.sv
module link_svc_req_det #(
  parameter int SYNC_DEPTH = 2,
  parameter int WORD_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        ack_pin,
  input  logic [1:0]        lclk_pin,
  input  logic [1:0]        buf_en,
  input  logic [1:0]        buf_port,
  input  logic [1:0]        tx_mask,
  input  logic [1:0]        rx_mask,
  input  logic              irq_en,
  output logic [WORD_W-1:0] req_word,
  output logic [2:0]        req_idx,
  output logic              svc_irq
);
  localparam int         NREQ  = 4;
  localparam logic [2:0] NOREQ = 3'(NREQ);
  localparam int         GAP   = WORD_W - 2 * NREQ;

  logic [SYNC_DEPTH-1:0][1:0] ack_q, clk_q;
  logic [1:0] ack_s, clk_s;
  logic [1:0] port_act, suppress, qual_tx, qual_rx;
  logic       loopback;
  logic [NREQ-1:0] stat, stat_nxt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ack_q <= '0;
      clk_q <= '0;
    end else begin
      ack_q <= {ack_q[SYNC_DEPTH-2:0], ack_pin};
      clk_q <= {clk_q[SYNC_DEPTH-2:0], lclk_pin};
    end

  assign ack_s    = ack_q[SYNC_DEPTH-1];
  assign clk_s    = clk_q[SYNC_DEPTH-1];
  assign loopback = &buf_en && (buf_port[0] == buf_port[1]);

  for (genvar p = 0; p < 2; p++) begin : g_port
    assign port_act[p] = (buf_en[0] && buf_port[0] == 1'(p)) ||
                         (buf_en[1] && buf_port[1] == 1'(p));
    assign suppress[p] = loopback && (buf_port[0] != 1'(p));
    assign qual_tx[p]  = ack_s[p] & tx_mask[p] & ~port_act[p] & ~suppress[p];
    assign qual_rx[p]  = clk_s[p] & rx_mask[p] & ~port_act[p] & ~suppress[p];
  end

  assign stat_nxt = {qual_tx[1], qual_rx[1], qual_tx[0], qual_rx[0]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      stat    <= '0;
      svc_irq <= 1'b0;
    end else begin
      stat    <= stat_nxt;
      svc_irq <= (|stat) & irq_en;
    end

  assign req_word = {stat, {GAP{1'b0}}, tx_mask[1], rx_mask[1], tx_mask[0], rx_mask[0]};

  always_comb begin
    req_idx = NOREQ;
    for (int i = 0; i < NREQ; i++)
      if (stat[i]) req_idx = 3'(NREQ - 1 - i);
  end

  // R6
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc_irq |-> ($past(irq_en) && $past(stat) != '0));
  // R2
  tx_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[3] || stat[1]) |-> ((!stat[3] || $past(tx_mask[1])) && (!stat[1] || $past(tx_mask[0]))));
  // R4
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(port_act[0]) |-> stat[1:0] == 2'b00);
  // R5
  loop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(suppress[1]) |-> stat[3:2] == 2'b00);
  // R8
  fall_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_s[0]) |=> !stat[1]);
  // R10
  idx_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat == '0) |-> req_idx == NOREQ);
endmodule

// File: tb/tb_link_svc_req_det.sv
module tb_link_svc_req_det;
  logic        clk = 0, rst_n = 0;
  logic [1:0]  ack_pin = 0, lclk_pin = 0, buf_en = 0, buf_port = 0, tx_mask = 0, rx_mask = 0;
  logic        irq_en = 0;
  logic [31:0] req_word;
  logic [2:0]  req_idx;
  logic        svc_irq;

  link_svc_req_det dut (.clk(clk), .rst_n(rst_n), .ack_pin(ack_pin), .lclk_pin(lclk_pin),
    .buf_en(buf_en), .buf_port(buf_port), .tx_mask(tx_mask), .rx_mask(rx_mask),
    .irq_en(irq_en), .req_word(req_word), .req_idx(req_idx), .svc_irq(svc_irq));

  always #10 clk = ~clk;

  typedef struct {
    int         due;
    logic [3:0] st;
    logic       irq;
    logic [3:0] mk;
    string      tag;
  } item_t;

  item_t q[$];
  int cyc = 0, checks = 0, fails = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [3:0] model_st();
    logic [1:0] act, sup, tx, rx;
    logic loop;
    loop = buf_en[0] & buf_en[1] & (buf_port[0] == buf_port[1]);
    for (int p = 0; p < 2; p++) begin
      act[p] = (buf_en[0] && buf_port[0] == 1'(p)) || (buf_en[1] && buf_port[1] == 1'(p));
      sup[p] = loop && buf_port[0] != 1'(p);
      tx[p]  = ack_pin[p] & tx_mask[p] & !act[p] & !sup[p];
      rx[p]  = lclk_pin[p] & rx_mask[p] & !act[p] & !sup[p];
    end
    return {tx[1], rx[1], tx[0], rx[0]};
  endfunction

  function automatic logic [2:0] model_idx(logic [3:0] s);
    if (s[3]) return 0;
    if (s[2]) return 1;
    if (s[1]) return 2;
    if (s[0]) return 3;
    return 4;
  endfunction

  function automatic logic [3:0] cur_mk();
    return {tx_mask[1], rx_mask[1], tx_mask[0], rx_mask[0]};
  endfunction

  task automatic push(int due, logic [3:0] st, logic irq, string tag);
    item_t it;
    it.due = due; it.st = st; it.irq = irq; it.mk = cur_mk(); it.tag = tag;
    q.push_back(it);
  endtask

  task automatic settle(string tag);
    logic [3:0] s;
    s = model_st();
    push(cyc + 5, s, (|s) & irq_en, tag);
    repeat (6) @(negedge clk);
    #1;
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      while (q.size() > 0 && q[0].due == cyc) begin
        item_t it;
        logic [31:0] ew;
        it = q.pop_front();
        ew = {it.st, 24'b0, it.mk};
        checks++;
        if (req_word !== ew || svc_irq !== it.irq || req_idx !== model_idx(it.st)) begin
          fails++;
          $display("FAIL %s: word=%h irq=%b idx=%0d expected word=%h irq=%b idx=%0d",
                   it.tag, req_word, svc_irq, req_idx, ew, it.irq, model_idx(it.st));
        end
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    int c;
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    settle("R1 reset state");
    tx_mask = 2'b11; rx_mask = 2'b11; irq_en = 1;
    settle("R9 mask field, R1 no request");
    // R7 latency from a single pin change
    c = cyc;
    ack_pin[0] = 1;
    push(c + 2, 4'b0000, 0, "R7 request not yet at edge 2");
    push(c + 3, 4'b0010, 0, "R7 request at edge 3, irq not yet");
    push(c + 4, 4'b0010, 1, "R7 irq at edge 4, R2 port0 transmit");
    repeat (6) @(negedge clk); #1;
    lclk_pin[1] = 1;
    settle("R3 port1 receive, R10 index");
    irq_en = 0;
    settle("R6 global enable off");
    irq_en = 1;
    tx_mask[0] = 0;
    settle("R2 mask clear removes transmit request");
    tx_mask[0] = 1;
    buf_en = 2'b01; buf_port = 2'b01;
    settle("R4 enabled buffer makes port1 busy");
    buf_en = 2'b00; buf_port = 2'b01;
    settle("R4 assigned but disabled buffer leaves port idle");
    ack_pin = 2'b11; lclk_pin = 2'b11;
    settle("R10 all requests index 0, R9 word");
    buf_en = 2'b11; buf_port = 2'b11;
    settle("R5 loopback on port1 silences port0");
    buf_port = 2'b00;
    settle("R5 loopback on port0 silences port1");
    buf_en = 2'b01;
    settle("R5 one buffer disabled, port1 requests again");
    buf_en = 2'b00;
    ack_pin = 2'b10; lclk_pin = 2'b00;
    settle("R8 requests clear when pins fall");
    ack_pin = 2'b00;
    rx_mask = 2'b01; tx_mask = 2'b00; lclk_pin = 2'b01;
    settle("R3 port0 receive index 3");
    buf_en = 2'b10; buf_port = 2'b00;
    settle("R8 request clears when port becomes busy");
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule